// File: doc/BRIEF.md
# I2C Target Address Recognizer

This block sits on the target side of a two-wire I2C bus and follows the clock (SCL) and data (SDA) lines. It samples both lines with the system clock. It finds START, repeated START and STOP conditions and shifts in the address phase that follows each START. It compares the address with a programmable own address, in either 7-bit or 10-bit mode. It also recognizes the all-zero general-call address. When an address byte is accepted, the block pulls SDA low for the acknowledge clock. SDA is modelled only as an open-drain pull-down enable: the block never drives the line high.

When an address is accepted, the block reports which kind of match it was and the read/write direction. Both results stay valid until the next START or STOP. Data bytes after the address are not acknowledged. The block has no clock stretching and no multi-controller arbitration. The bus SCL half period must be longer than about six system clock cycles, because the inputs pass through a synchronizer and an edge-detect stage.

Top module: `i2c_tgt_addr_rx`

## Requirements
- R1: After reset, sda_oe_o is 0 (SDA released), match_o is 0 (none) and rnw_o is 0.
- R2: In 7-bit mode (addr10_en_i=0), the first byte after a START is compared as follows. Its bits 7..1, sent MSB first, are compared with own_addr_i[6:0]. On equality, the byte is acknowledged, match_o becomes 1 (own address) and rnw_o takes bit 0 of the byte (1 = read).
- R3: An address byte that matches nothing is not acknowledged and match_o stays 0. Every later byte is also left unacknowledged until the next START.
- R4: The byte 0x00 is accepted as a general call only when gcall_en_i=1. It is then acknowledged, match_o becomes 2 and rnw_o is 0. When gcall_en_i=0, or for 0x01 (general call with the read bit set), there is no acknowledge.
- R5: The pull-down goes on after the SCL falling edge of the 8th bit of an accepted byte, and is active before the 9th SCL rising edge. It is off during the 8th bit's SCL high phase. It is released after the 9th SCL falling edge.
- R6: A START or a repeated START restarts the address phase from bit 0, even in the middle of a byte. A STOP returns the block to idle. Either condition releases SDA and clears match_o to 0.
- R7: In 10-bit mode (addr10_en_i=1), a first byte of 11110, then own_addr_i[9:8], then a write bit 0, is acknowledged while match_o stays 0. The next byte is then compared with own_addr_i[7:0]. On equality it is acknowledged and match_o=1, rnw_o=0. On inequality it is not acknowledged and match_o stays 0.
- R8: In 10-bit mode, the prefix byte with the read bit 1 is acknowledged, with match_o=1 and rnw_o=1, only after a full 10-bit match and a repeated START with no STOP in between. Otherwise it is not acknowledged.
- R9: In 10-bit mode, a first byte that is neither the own prefix nor an enabled general call is not acknowledged. This includes a prefix with the wrong high bits and a byte that carries the own 7-bit address.
- R10: Once match_o is non-zero, match_o and rnw_o do not change until the next START or STOP, even while further bytes are clocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line (wired value), asynchronous |
| own_addr_i | input | 10 | Own address; bits 6..0 are used in 7-bit mode, all ten bits in 10-bit mode |
| addr10_en_i | input | 1 | 1 selects 10-bit addressing |
| gcall_en_i | input | 1 | 1 allows the general-call address to be acknowledged |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| match_o | output | 2 | 0 none, 1 own address, 2 general call |
| rnw_o | output | 1 | Direction of the matched address, 1 = read |

## Verification
The bench drives the bus through a wired-AND model, so the acknowledge is seen on the line itself. The own address is sent as a write and as a read, which separates direction capture from address compare. Near-miss addresses are sent in both modes: one low bit off, the wrong prefix high bits, and the 7-bit address while 10-bit mode is on. Each of these must fail, which rules out a partial compare. The general call is tried enabled, disabled and with the read bit set. Repeated STARTs are placed after partial bytes and after a full 10-bit match, and a STOP is placed before a prefix read. These patterns separate a restart of the bit counter from the memory of an earlier 10-bit match.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [4:0]  TEN_BIT_PFX = 5'b11110;

  typedef enum logic [1:0] {
    MATCH_NONE  = 2'd0,
    MATCH_OWN   = 2'd1,
    MATCH_GCALL = 2'd2
  } match_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR1,
    ST_ADDR2,
    ST_ACK,
    ST_HOLD
  } state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // idle bus is high, so reset to ones
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '1;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  logic scl_hi;
  assign scl_hi     = scl_i & scl_q;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_hi & sda_q & ~sda_i;
  assign stop_o     = scl_hi & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_addr_fsm.sv
module i2c_addr_fsm
  import i2c_tgt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_bit_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              addr10_en_i,
  input  logic              gcall_en_i,
  output logic              sda_oe_o,
  output match_e            match_o,
  output logic              rnw_o
);
  state_e            state_q, ack_next_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              sda_oe_q, rnw_q;
  match_e            match_q;
  logic              hi_ok_q;   // full 10-bit match seen since last STOP

  logic gc_hit, own7_hit, pfx_hit, lo_hit, byte_end, shifting;

  always_comb begin
    gc_hit   = gcall_en_i && (shreg_q == '0);
    own7_hit = !addr10_en_i && (shreg_q[7:1] == own_addr_i[6:0]);
    pfx_hit  = addr10_en_i && (shreg_q[7:3] == TEN_BIT_PFX)
               && (shreg_q[2:1] == own_addr_i[9:8]);
    lo_hit   = (shreg_q == own_addr_i[7:0]);
    byte_end = scl_fall_i && (bit_cnt_q == CNT_W'(BYTE_W));
    shifting = ((state_q == ST_ADDR1) || (state_q == ST_ADDR2)) && scl_rise_i
               && (bit_cnt_q < CNT_W'(BYTE_W));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ack_next_q <= ST_HOLD;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      sda_oe_q   <= 1'b0;
      match_q    <= MATCH_NONE;
      rnw_q      <= 1'b0;
      hi_ok_q    <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_ADDR1;
      bit_cnt_q <= '0;
      sda_oe_q  <= 1'b0;
      match_q   <= MATCH_NONE;
      rnw_q     <= 1'b0;
    end else if (stop_i) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      sda_oe_q  <= 1'b0;
      match_q   <= MATCH_NONE;
      rnw_q     <= 1'b0;
      hi_ok_q   <= 1'b0;
    end else begin
      if (shifting) begin
        shreg_q   <= {shreg_q[BYTE_W-2:0], sda_bit_i};
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end
      unique case (state_q)
        ST_ADDR1: if (byte_end) begin
          bit_cnt_q <= '0;
          if (gc_hit) begin
            sda_oe_q   <= 1'b1;
            match_q    <= MATCH_GCALL;
            rnw_q      <= 1'b0;
            state_q    <= ST_ACK;
            ack_next_q <= ST_HOLD;
          end else if (own7_hit) begin
            sda_oe_q   <= 1'b1;
            match_q    <= MATCH_OWN;
            rnw_q      <= shreg_q[0];
            state_q    <= ST_ACK;
            ack_next_q <= ST_HOLD;
          end else if (pfx_hit && !shreg_q[0]) begin
            sda_oe_q   <= 1'b1;
            state_q    <= ST_ACK;
            ack_next_q <= ST_ADDR2;
          end else if (pfx_hit && shreg_q[0] && hi_ok_q) begin
            sda_oe_q   <= 1'b1;
            match_q    <= MATCH_OWN;
            rnw_q      <= 1'b1;
            state_q    <= ST_ACK;
            ack_next_q <= ST_HOLD;
          end else begin
            state_q <= ST_HOLD;
          end
        end
        ST_ADDR2: if (byte_end) begin
          bit_cnt_q <= '0;
          if (lo_hit) begin
            sda_oe_q   <= 1'b1;
            match_q    <= MATCH_OWN;
            rnw_q      <= 1'b0;
            hi_ok_q    <= 1'b1;
            state_q    <= ST_ACK;
            ack_next_q <= ST_HOLD;
          end else begin
            state_q <= ST_HOLD;
          end
        end
        ST_ACK: if (scl_fall_i) begin
          sda_oe_q <= 1'b0;
          state_q  <= ack_next_q;
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;
  assign match_o  = match_q;
  assign rnw_o    = rnw_q;

  AST_OE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_q) |-> $past(scl_fall_i)); // R5
  AST_OE_OFF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_q) |-> $past(scl_fall_i || start_i || stop_i)); // R5
  AST_COND_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || stop_i) |=> (!sda_oe_q && match_q == MATCH_NONE)); // R6
  AST_MATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_q != MATCH_NONE && !start_i && !stop_i) |=> ($stable(match_q) && $stable(rnw_q))); // R10
  AST_GCALL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_q == MATCH_GCALL) |-> !rnw_q); // R4
endmodule

// File: rtl/i2c_tgt_addr_rx.sv
module i2c_tgt_addr_rx
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              addr10_en_i,
  input  logic              gcall_en_i,
  output logic              sda_oe_o,
  output logic [1:0]        match_o,
  output logic              rnw_o
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start, stop;
  match_e match;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    ({scl_s, sda_s})
  );

  i2c_bus_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  i2c_addr_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start),
    .stop_i      (stop),
    .sda_bit_i   (sda_s),
    .own_addr_i  (own_addr_i),
    .addr10_en_i (addr10_en_i),
    .gcall_en_i  (gcall_en_i),
    .sda_oe_o    (sda_oe_o),
    .match_o     (match),
    .rnw_o       (rnw_o)
  );

  assign match_o = match;
endmodule

// File: tb/sim_i2c_tgt_addr_rx.sv
module sim_i2c_tgt_addr_rx;
  localparam int Q = 8;   // system cycles per bus quarter step

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic [9:0] own_addr = 10'h2A5;
  logic addr10_en = 1'b0, gcall_en = 1'b1;
  logic sda_oe, rnw;
  logic [1:0] match;
  logic sda_line;

  int n_cmp = 0, n_err = 0;
  logic acked, oe_b8_hi, oe_pre9, oe_post9;

  always #2 clk = ~clk;

  assign sda_line = sda_drv & ~sda_oe;

  i2c_tgt_addr_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .own_addr_i(own_addr), .addr10_en_i(addr10_en), .gcall_en_i(gcall_en),
    .sda_oe_o(sda_oe), .match_o(match), .rnw_o(rnw)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_drv = 1'b1; hold(Q);
    scl_drv = 1'b1; hold(Q);
    sda_drv = 1'b0; hold(Q);
    scl_drv = 1'b0; hold(Q);
  endtask

  task automatic bus_stop;
    sda_drv = 1'b0; hold(Q);
    scl_drv = 1'b1; hold(Q);
    sda_drv = 1'b1; hold(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; hold(Q);
      scl_drv = 1'b1; hold(Q);
      if (i == 0) oe_b8_hi = sda_oe;
      scl_drv = 1'b0; hold(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
    sda_drv = 1'b1; hold(Q);
    oe_pre9 = sda_oe;
    scl_drv = 1'b1; hold(Q/2);
    acked = ~sda_line;
    hold(Q/2);
    scl_drv = 1'b0; hold(Q);
    oe_post9 = sda_oe;
  endtask

  task automatic t_reset;
    chk(sda_oe, 0, "R1 sda_oe after reset");
    chk(match, 0, "R1 match after reset");
    chk(rnw, 0, "R1 rnw after reset");
  endtask

  task automatic t_7bit;
    addr10_en = 0; gcall_en = 1;
    bus_start; send_byte({7'h25, 1'b0});
    chk(acked, 1, "R2 own write ack");
    chk(match, 1, "R2 own write match");
    chk(rnw, 0, "R2 own write rnw");
    send_byte(8'h55);
    chk(match, 1, "R10 match held over data byte");
    chk(rnw, 0, "R10 rnw held over data byte");
    bus_stop;
    chk(match, 0, "R6 stop clears match");
    bus_start; send_byte({7'h25, 1'b1});
    chk(acked, 1, "R2 own read ack");
    chk(match, 1, "R2 own read match");
    chk(rnw, 1, "R2 own read rnw");
    send_byte(8'h00);
    chk(rnw, 1, "R10 rnw held");
    bus_stop;
  endtask

  task automatic t_mismatch;
    addr10_en = 0;
    bus_start; send_byte({7'h24, 1'b0});
    chk(acked, 0, "R3 wrong address no ack");
    chk(match, 0, "R3 wrong address no match");
    send_byte({7'h25, 1'b0});
    chk(acked, 0, "R3 own byte ignored until START");
    chk(match, 0, "R3 still no match");
    bus_stop;
  endtask

  task automatic t_gcall;
    addr10_en = 0; gcall_en = 1;
    bus_start; send_byte(8'h00);
    chk(acked, 1, "R4 general call ack");
    chk(match, 2, "R4 general call match code");
    chk(rnw, 0, "R4 general call rnw");
    bus_start; send_byte(8'h01);
    chk(acked, 0, "R4 general call read no ack");
    chk(match, 0, "R4 general call read no match");
    bus_stop;
    gcall_en = 0;
    bus_start; send_byte(8'h00);
    chk(acked, 0, "R4 general call disabled no ack");
    chk(match, 0, "R4 general call disabled no match");
    bus_stop;
    gcall_en = 1;
  endtask

  task automatic t_ack_timing;
    addr10_en = 0;
    bus_start; send_byte({7'h25, 1'b0});
    chk(oe_b8_hi, 0, "R5 released during 8th SCL high");
    chk(oe_pre9, 1, "R5 pulled before 9th rise");
    chk(oe_post9, 0, "R5 released after 9th fall");
    bus_stop;
  endtask

  task automatic t_abort;
    addr10_en = 0;
    bus_start; send_bits({7'h25, 1'b0}, 4);
    bus_start; send_byte({7'h25, 1'b0});
    chk(acked, 1, "R6 repeated START mid byte restarts");
    chk(match, 1, "R6 match after restart");
    bus_start;
    chk(match, 0, "R6 repeated START clears match");
    send_bits(8'hFF, 3);
    bus_stop;
    chk(sda_oe, 0, "R6 stop mid byte releases");
    bus_start; send_byte({7'h25, 1'b1});
    chk(acked, 1, "R6 address after stop abort");
    bus_stop;
  endtask

  task automatic t_10bit;
    addr10_en = 1; gcall_en = 1;
    bus_start; send_byte(8'hF4);
    chk(acked, 1, "R7 prefix write ack");
    chk(match, 0, "R7 no match after prefix only");
    send_byte(8'hA5);
    chk(acked, 1, "R7 low byte ack");
    chk(match, 1, "R7 full match");
    chk(rnw, 0, "R7 rnw write");
    bus_start; send_byte(8'hF5);
    chk(acked, 1, "R8 prefix read after repeated START");
    chk(match, 1, "R8 read match");
    chk(rnw, 1, "R8 rnw read");
    bus_stop;
    bus_start; send_byte(8'hF5);
    chk(acked, 0, "R8 prefix read after STOP no ack");
    chk(match, 0, "R8 no match after STOP");
    bus_stop;
    bus_start; send_byte(8'hF4); send_byte(8'hA4);
    chk(acked, 0, "R7 wrong low byte no ack");
    chk(match, 0, "R7 wrong low byte no match");
    bus_stop;
    bus_start; send_byte(8'hF2);
    chk(acked, 0, "R9 wrong prefix high bits");
    bus_start; send_byte({7'h25, 1'b0});
    chk(acked, 0, "R9 7-bit address in 10-bit mode");
    chk(match, 0, "R9 no match");
    bus_stop;
    addr10_en = 0;
  endtask

  initial begin
    hold(5);
    t_reset;
    rst_n = 1'b1;
    hold(4);
    t_reset;
    t_7bit;
    t_mismatch;
    t_gcall;
    t_ack_timing;
    t_abort;
    t_10bit;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule